// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the sequence of column addresses that the data beats of an SDRAM read or write burst touch. A single-cycle start strobe carries the starting column, a three-bit burst-length code and a one-bit ordering select. From the next cycle onward the block presents one column address per clock, with a valid flag on every beat and a last flag on the final beat of a finite burst.

Finite bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block of that size that holds the starting column. The ordering is either sequential, where the low bits count up and wrap, or interleaved, where the low bits are the start column XORed with the beat index. A full-page burst walks all 256 columns in sequential order and keeps wrapping until a stop arrives. A stop input ends any burst with no further beat, and a new start ends the current burst at once and begins the new one. Command generation and data movement sit outside this block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While and directly after synchronous reset, `beat_vld_o` and `last_o` are 0.
- R2: A start sampled on a clock edge makes the first beat appear after that edge: `beat_vld_o` is 1 and `col_o` equals the sampled start column.
- R3: The length code gives the beat count: 3'b000 = 1, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page; beats follow one per clock with no gap and `beat_vld_o` drops after the final one.
- R4: With `btype_i` = 0 (sequential) and a length of 2^n beats, beat k has the low n bits equal to (start low n bits + k) mod 2^n, and the upper 8-n bits equal to those of the start column.
- R5: With `btype_i` = 1 (interleaved) and a length of 2^n beats, beat k equals the start column with its low n bits XORed with k.
- R6: In full-page mode beat k is (start + k) mod 256, the burst continues past 256 beats until stopped, `last_o` is never 1, and the ordering bit has no effect.
- R7: On a finite burst `last_o` is 1 on the final beat only, and `beat_vld_o` is 0 on the following cycle unless a start was sampled.
- R8: A stop sampled on an edge with no start ends the burst: no beat is presented after that edge; a stop while idle has no effect.
- R9: A start sampled during a burst truncates it and the next cycle shows beat 0 of the new burst; a start sampled together with a stop begins the new burst.
- R10: The unused length codes 3'b100, 3'b101 and 3'b110 act as a length of 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Column command strobe, one cycle per burst |
| start_col_i | input | 8 | Starting column address |
| blen_code_i | input | 3 | Burst-length code |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop |
| col_o | output | 8 | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | This beat is the final one of a finite burst |

## Verification
The hardest state to reach is a full-page burst that has wrapped past column 255 and is still running, since it takes more than 256 clocks of an unbroken burst before the stop can be tested there. The bench starts a full-page burst near the top of the column space with the interleaved bit set, follows every one of 260 beats through the wrap, and then raises stop on the final checked beat. Truncation is reached by raising a new start mid-burst, and by raising start and stop in the same cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int COL_W   = 8;
    localparam int CODE_W  = 3;
    localparam int IDX_W   = $clog2(COL_W + 1);

    typedef enum logic [CODE_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_code_e;

    typedef struct packed {
        logic [COL_W-1:0] wrap_mask;  // bits that move during the burst
        logic             xor_order;  // interleaved ordering
        logic             page_run;   // full-page, runs until stopped
    } burst_mode_t;

    // Number of low column bits that change within a burst.
    function automatic logic [IDX_W-1:0] span_bits(input logic [CODE_W-1:0] code);
        case (code)
            BLEN_2:    span_bits = IDX_W'(1);
            BLEN_4:    span_bits = IDX_W'(2);
            BLEN_8:    span_bits = IDX_W'(3);
            BLEN_PAGE: span_bits = IDX_W'(COL_W);
            default:   span_bits = '0;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] low_mask(input logic [IDX_W-1:0] n);
        logic [COL_W-1:0] m;
        for (int b = 0; b < COL_W; b++) begin
            m[b] = (IDX_W'(b) < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              btype_i,
    output burst_mode_t       mode_o
);

    logic page_sel;

    always_comb begin
        page_sel          = (code_i == BLEN_PAGE);
        mode_o.wrap_mask  = low_mask(span_bits(code_i));
        mode_o.page_run   = page_sel;
        // full-page runs only in sequential order
        mode_o.xor_order  = btype_i & ~page_sel;
    end

endmodule

// File: rtl/colgen_beat_ctl.sv
module colgen_beat_ctl
    import colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_mode_t      mode_i,
    input  logic             stop_i,
    output logic             active_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_idx_o,
    output burst_mode_t      mode_o,
    output logic             final_o
);

    logic             active_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    burst_mode_t      mode_q;
    logic             final_beat;

    always_comb begin
        final_beat = active_q & ~mode_q.page_run & (idx_q == mode_q.wrap_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            idx_q    <= '0;
            mode_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            base_q   <= start_col_i;
            idx_q    <= '0;
            mode_q   <= mode_i;
        end else if (active_q) begin
            if (stop_i || final_beat) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + COL_W'(1);
            end
        end
    end

    assign active_o   = active_q;
    assign base_o     = base_q;
    assign beat_idx_o = idx_q;
    assign mode_o     = mode_q;
    assign final_o    = final_beat;

endmodule

// File: rtl/colgen_addr_mix.sv
module colgen_addr_mix
    import colgen_pkg::*;
(
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_idx_i,
    input  burst_mode_t      mode_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] xor_low;
    logic [COL_W-1:0] moved;

    always_comb begin
        seq_low = base_i + beat_idx_i;
        xor_low = base_i ^ beat_idx_i;
        moved   = mode_i.xor_order ? xor_low : seq_low;
        col_o   = (base_i & ~mode_i.wrap_mask) | (moved & mode_i.wrap_mask);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_code_i,
    input  logic              btype_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              beat_vld_o,
    output logic              last_o
);

    burst_mode_t      new_mode;
    burst_mode_t      run_mode;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat_idx;
    logic             run_page;

    colgen_mode_dec u_dec (
        .code_i  (blen_code_i),
        .btype_i (btype_i),
        .mode_o  (new_mode)
    );

    colgen_beat_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .mode_i      (new_mode),
        .stop_i      (stop_i),
        .active_o    (beat_vld_o),
        .base_o      (base),
        .beat_idx_o  (beat_idx),
        .mode_o      (run_mode),
        .final_o     (last_o)
    );

    colgen_addr_mix u_mix (
        .base_i     (base),
        .beat_idx_i (beat_idx),
        .mode_i     (run_mode),
        .col_o      (col_o)
    );

    assign run_page = run_mode.page_run;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk
    import colgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o,
    input logic             run_page
);

    // R1: nothing is presented in the cycle after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> !beat_vld_o && !last_o);

    // R2 and R9: a sampled start yields beat 0 at the start column
    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> beat_vld_o && (col_o == $past(start_col_i)));

    // R7: the final beat is followed by an idle cycle
    p_last_closes_r7: assert property (@(posedge clk) disable iff (rst)
        last_o && !start_i |=> !beat_vld_o);

    // R7: last only accompanies a valid beat
    p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
        last_o |-> beat_vld_o);

    // R8: a stop without a start leaves no further beat
    p_stop_halts_r8: assert property (@(posedge clk) disable iff (rst)
        stop_i && !start_i |=> !beat_vld_o);

    // R6: full-page never flags a last beat
    p_page_no_last_r6: assert property (@(posedge clk) disable iff (rst)
        run_page && beat_vld_o |-> !last_o);

    // R6: full-page steps by one column and wraps at the top
    p_page_step_r6: assert property (@(posedge clk) disable iff (rst)
        run_page && beat_vld_o && !start_i && !stop_i
        |=> beat_vld_o && (col_o == $past(col_o) + COL_W'(1)));

endmodule

bind sdram_burst_colgen colgen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .run_page    (run_page)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [7:0] start_col_i;
    logic [2:0] blen_code_i;
    logic       btype_i;
    logic       stop_i;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sdram_burst_colgen dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_code_i (blen_code_i),
        .btype_i     (btype_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .last_o      (last_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int span_of(input logic [2:0] code);
        case (code)
            3'b001:  return 1;
            3'b010:  return 2;
            3'b011:  return 3;
            3'b111:  return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic il, input int k);
        logic [7:0] m;
        logic [7:0] kk;
        m  = 8'((1 << span_of(code)) - 1);
        kk = 8'(k);
        if (il && code != 3'b111) return s ^ (kk & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    // drive at a falling edge
    task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic il);
        start_i     = 1'b1;
        start_col_i = s;
        blen_code_i = code;
        btype_i     = il;
    endtask

    task automatic run_finite(input logic [7:0] s, input logic [2:0] code,
                              input logic il, input string tag);
        int n;
        n = 1 << span_of(code);
        @(negedge clk);
        issue(s, code, il);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 first beat valid", 32'(beat_vld_o), 32'd1);
        chk("R2 first beat col", 32'(col_o), 32'(s));
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            chk({tag, " beat col"}, 32'(col_o), 32'(exp_col(s, code, il, k)));
            chk("R3 beat valid", 32'(beat_vld_o), 32'd1);
            chk("R7 last flag", 32'(last_o), 32'(k == n - 1));
        end
        @(negedge clk);
        chk("R3 idle after burst", 32'(beat_vld_o), 32'd0);
        chk("R7 last cleared", 32'(last_o), 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start_i = 1'b0; stop_i = 1'b0;
        start_col_i = '0; blen_code_i = '0; btype_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(beat_vld_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(beat_vld_o), 32'd0);
        chk("R1 last after reset", 32'(last_o), 32'd0);
    endtask

    task automatic t_sequential;
        for (int c = 0; c < 4; c++) run_finite(8'h2D, 3'(c), 1'b0, "R4");
        run_finite(8'hF6, 3'b011, 1'b0, "R4");
    endtask

    task automatic t_interleaved;
        for (int c = 1; c < 4; c++) run_finite(8'h2D, 3'(c), 1'b1, "R5");
        run_finite(8'hB6, 3'b011, 1'b1, "R5");
    endtask

    task automatic t_reserved;
        run_finite(8'h5A, 3'b100, 1'b0, "R10");
        run_finite(8'h5B, 3'b101, 1'b1, "R10");
        run_finite(8'h5C, 3'b110, 1'b0, "R10");
    endtask

    task automatic t_fullpage;
        @(negedge clk);
        issue(8'hFE, 3'b111, 1'b1);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 260; k++) begin
            if (k > 0) @(negedge clk);
            chk("R6 page col", 32'(col_o), 32'(8'(8'hFE + k)));
            chk("R6 page valid", 32'(beat_vld_o), 32'd1);
            chk("R6 page no last", 32'(last_o), 32'd0);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 page stopped", 32'(beat_vld_o), 32'd0);
    endtask

    task automatic t_stop;
        @(negedge clk);
        issue(8'h10, 3'b011, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 beat0", 32'(col_o), 32'h10);
        @(negedge clk);
        chk("R8 beat1", 32'(col_o), 32'h11);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 no beat after stop", 32'(beat_vld_o), 32'd0);
        chk("R8 no last after stop", 32'(last_o), 32'd0);
        @(negedge clk);
        chk("R8 stays idle", 32'(beat_vld_o), 32'd0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 idle stop no beat", 32'(beat_vld_o), 32'd0);
        run_finite(8'h33, 3'b001, 1'b0, "R8");
    endtask

    task automatic t_truncate;
        @(negedge clk);
        issue(8'h13, 3'b011, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 first burst beat0", 32'(col_o), 32'h13);
        @(negedge clk);
        chk("R9 first burst beat1", 32'(col_o), 32'h14);
        issue(8'h42, 3'b010, 1'b1);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk("R9 new burst col", 32'(col_o), 32'(8'h42 ^ 8'(k)));
            chk("R9 new burst last", 32'(last_o), 32'(k == 3));
        end
        @(negedge clk);
        chk("R9 idle after new burst", 32'(beat_vld_o), 32'd0);
        issue(8'h80, 3'b011, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        issue(8'h77, 3'b000, 1'b0);
        stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk("R9 start beats stop valid", 32'(beat_vld_o), 32'd1);
        chk("R9 start beats stop col", 32'(col_o), 32'h77);
        chk("R9 start beats stop last", 32'(last_o), 32'd1);
        @(negedge clk);
        chk("R9 idle after", 32'(beat_vld_o), 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_sequential();
        t_interleaved();
        t_reserved();
        t_fullpage();
        t_stop();
        t_truncate();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule